// File: doc/BRIEF.md
# Write Data Width Lane Multiplexer

This block sits between a write command queue and the data pins of an external memory bus. It takes one 64-bit write word at a time and sends it out as a short series of transfers, or beats, that suit the device behind the selected chip select. A full-width device receives two 32-bit beats per word. A halfword device receives four 16-bit beats per word, and each beat is steered onto one 16-bit half of the bus. The least significant part of the word always goes first. With every beat the block drives a per-byte lane enable, which serves as both the byte-mask enable and the strobe enable for the bus.

Each of the two chip selects has its own 3-bit mux-config code. The block samples the code for the addressed chip select at the moment it accepts a word. The input side uses a valid/ready handshake. The output side presents one beat at a time and advances on a ready from downstream. While a word is still being sent out, the input is held off. A word that arrives with a reserved code is taken in and dropped, and the block reports it on a one-cycle error pulse.

Top module: `wr_lane_mux`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `cfg_err` and `out_lane_en` are 0 and `in_ready` is 1.
- R2: `mux_cfg[2:0]` holds the code for chip select 0 and `mux_cfg[5:3]` holds the code for chip select 1. The code is sampled only on the cycle the word is accepted, so later changes to `mux_cfg` do not affect that word.
- R3: Codes 0 and 1 give two beats. Beat 0 carries word bits [31:0] and beat 1 carries bits [63:32]. `out_lane_en` is 4'b1111 on both beats.
- R4: Codes 2 and 7 give four beats. Beat k carries word bits [16k+15:16k] on `out_data[15:0]`, `out_data[31:16]` is zero, and `out_lane_en` is 4'b0011.
- R5: Code 3 gives four beats. Beat k carries word bits [16k+15:16k] on `out_data[31:16]`, `out_data[15:0]` is zero, and `out_lane_en` is 4'b1100.
- R6: Codes 4, 5 and 6 are reserved. A word with a reserved code is accepted, no beat is produced, and `cfg_err` is 1 for exactly the one cycle after acceptance.
- R7: The first beat is valid on the cycle after acceptance. `in_ready` stays 0 from then until the cycle after the last beat is taken, and at that point it returns to 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the beat on `out_data` and `out_lane_en` is held unchanged.
- R9: When `out_valid` is 0, `out_data` and `out_lane_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_cfg | input | 6 | Mux-config codes, chip select 0 in [2:0] and chip select 1 in [5:3] |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Block can take a word |
| in_cs | input | 1 | Chip select of the offered word |
| in_data | input | 64 | Write word |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 32 | Beat data on the external lanes |
| out_lane_en | output | 4 | Byte lane enables (mask and strobe) |
| cfg_err | output | 1 | Pulse: a word with a reserved code was dropped |

## Verification
A word is accepted on a rising edge. Its first beat and any error pulse appear on the cycle that follows that edge. The next beat shows up one cycle after downstream takes the current one, and `in_ready` comes back one cycle after the last beat is taken. The bench drives and samples every signal on the falling edge. It expects each result in the exact cycle these delays give, and it stalls downstream on alternate cycles so that held beats are checked as well. The sweep covers all eight codes on both chip selects and several data words. The mux-config input is scrambled right after each acceptance to show that the code was captured when the word was taken.

// File: rtl/wlm_pkg.sv
package wlm_pkg;

    localparam int IN_W      = 64;
    localparam int BUS_W     = 32;
    localparam int HALF_W    = 16;
    localparam int CODE_W    = 3;
    localparam int CS_NUM    = 2;
    localparam int CS_W      = (CS_NUM > 1) ? $clog2(CS_NUM) : 1;
    localparam int LANES     = BUS_W / 8;
    localparam int HALVES    = IN_W / HALF_W;
    localparam int FULLS     = IN_W / BUS_W;
    localparam int IDX_W     = $clog2(HALVES);
    localparam int FULL_IDXW = (FULLS > 1) ? $clog2(FULLS) : 1;

    typedef enum logic [1:0] {
        MODE_W32    = 2'd0,
        MODE_H16_LO = 2'd1,
        MODE_H16_HI = 2'd2,
        MODE_BAD    = 2'd3
    } mode_e;

    typedef logic [IDX_W-1:0] beat_idx_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [LANES-1:0] lane_en;
    } beat_t;

    function automatic mode_e decode_code(logic [CODE_W-1:0] code);
        case (code)
            3'd0, 3'd1: return MODE_W32;
            3'd2, 3'd7: return MODE_H16_LO;
            3'd3:       return MODE_H16_HI;
            default:    return MODE_BAD;
        endcase
    endfunction

    function automatic beat_idx_t last_beat(mode_e m);
        if (m == MODE_W32) return beat_idx_t'(FULLS - 1);
        return beat_idx_t'(HALVES - 1);
    endfunction

endpackage

// File: rtl/wlm_cfg_decode.sv
module wlm_cfg_decode
    import wlm_pkg::*;
(
    input  logic [CS_NUM*CODE_W-1:0] mux_cfg,
    input  logic [CS_W-1:0]          cs,
    output mode_e                    mode
);
    logic [CODE_W-1:0] fields [CS_NUM];

    for (genvar g = 0; g < CS_NUM; g++) begin : g_field
        assign fields[g] = mux_cfg[g*CODE_W +: CODE_W];
    end

    assign mode = decode_code(fields[cs]);
endmodule

// File: rtl/wlm_beat_seq.sv
module wlm_beat_seq
    import wlm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    input  mode_e           mode_in,
    input  logic            out_ready,
    output logic            in_ready,
    output logic            busy,
    output logic [IN_W-1:0] word_q,
    output mode_e           mode_q,
    output beat_idx_t       idx_q,
    output logic            err_q
);
    logic accept;
    assign in_ready = ~busy;
    assign accept   = in_valid & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            err_q  <= 1'b0;
            idx_q  <= '0;
            mode_q <= MODE_W32;
            word_q <= '0;
        end else begin
            err_q <= 1'b0;
            if (accept) begin
                if (mode_in == MODE_BAD) begin
                    err_q <= 1'b1;
                end else begin
                    busy   <= 1'b1;
                    word_q <= in_data;
                    mode_q <= mode_in;
                    idx_q  <= '0;
                end
            end else if (busy && out_ready) begin
                if (idx_q == last_beat(mode_q)) busy <= 1'b0;
                else                            idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wlm_lane_steer.sv
module wlm_lane_steer
    import wlm_pkg::*;
(
    input  logic            valid,
    input  logic [IN_W-1:0] word,
    input  mode_e           mode,
    input  beat_idx_t       idx,
    output beat_t           beat
);
    localparam int HALF_LANES = HALF_W / 8;

    logic [HALF_W-1:0] halves [HALVES];
    logic [BUS_W-1:0]  fulls  [FULLS];
    logic [HALF_W-1:0] half_sel;
    logic [BUS_W-1:0]  full_sel;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign halves[h] = word[h*HALF_W +: HALF_W];
    end
    for (genvar f = 0; f < FULLS; f++) begin : g_full
        assign fulls[f] = word[f*BUS_W +: BUS_W];
    end

    assign half_sel = halves[idx];
    assign full_sel = fulls[idx[FULL_IDXW-1:0]];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam bit UPPER = (l >= LANES/2);
        logic en;
        assign en = valid && ((mode == MODE_W32) ||
                              (mode == MODE_H16_LO && !UPPER) ||
                              (mode == MODE_H16_HI &&  UPPER));
        assign beat.lane_en[l]     = en;
        assign beat.data[l*8 +: 8] = !en ? 8'h00 :
            (mode == MODE_W32) ? full_sel[l*8 +: 8]
                               : half_sel[(l % HALF_LANES)*8 +: 8];
    end
endmodule

// File: rtl/wr_lane_mux.sv
module wr_lane_mux
    import wlm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CS_NUM*CODE_W-1:0] mux_cfg,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CS_W-1:0]          in_cs,
    input  logic [IN_W-1:0]          in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [BUS_W-1:0]         out_data,
    output logic [LANES-1:0]         out_lane_en,
    output logic                     cfg_err
);
    mode_e           mode_sel;
    mode_e           mode_q;
    logic [IN_W-1:0] word_q;
    beat_idx_t       idx_q;
    logic            busy;
    beat_t           beat;

    wlm_cfg_decode u_dec (
        .mux_cfg (mux_cfg),
        .cs      (in_cs),
        .mode    (mode_sel)
    );

    wlm_beat_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mode_in   (mode_sel),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .busy      (busy),
        .word_q    (word_q),
        .mode_q    (mode_q),
        .idx_q     (idx_q),
        .err_q     (cfg_err)
    );

    wlm_lane_steer u_steer (
        .valid (busy),
        .word  (word_q),
        .mode  (mode_q),
        .idx   (idx_q),
        .beat  (beat)
    );

    assign out_valid   = busy;
    assign out_data    = beat.data;
    assign out_lane_en = beat.lane_en;
endmodule

// File: rtl/wlm_check.sv
module wlm_check
    import wlm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_data,
    input logic [LANES-1:0] out_lane_en,
    input logic             cfg_err
);
    logic [BUS_W-1:0] byte_mask;
    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign byte_mask[l*8 +: 8] = {8{out_lane_en[l]}};
    end

    AST_BUSY_HOLDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R7

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lane_en))); // R8

    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lane_en == 4'b1111 || out_lane_en == 4'b0011 || out_lane_en == 4'b1100)); // R4

    AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~byte_mask) == '0)); // R5

    AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!out_valid && $past(in_valid && in_ready))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_lane_en == '0 && out_data == '0)); // R9
endmodule

bind wr_lane_mux wlm_check u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_lane_en (out_lane_en),
    .cfg_err     (cfg_err)
);

// File: tb/wr_lane_mux_test.sv
module wr_lane_mux_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  mux_cfg = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:0]  in_cs = '0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_lane_en;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wr_lane_mux uut (
        .clk (clk), .rst (rst), .mux_cfg (mux_cfg),
        .in_valid (in_valid), .in_ready (in_ready), .in_cs (in_cs),
        .in_data (in_data), .out_valid (out_valid), .out_ready (out_ready),
        .out_data (out_data), .out_lane_en (out_lane_en), .cfg_err (cfg_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0: full width, 1: low halfword lane, 2: high halfword lane, 3: reserved
    function automatic int kind_of(int code);
        if (code <= 1) return 0;
        if (code == 2 || code == 7) return 1;
        if (code == 3) return 2;
        return 3;
    endfunction

    task automatic run_word(input int cs, input int code, input logic [63:0] d, input bit bp);
        int k, nb, b;
        bit toggle, rdy;
        logic [2:0] own, other;
        logic [31:0] exp_d;
        logic [3:0]  exp_l;
        k     = kind_of(code);
        own   = 3'(code);
        other = 3'((code + 3) % 8);
        @(negedge clk);
        mux_cfg  = (cs == 1) ? {own, other} : {other, own};
        in_cs    = 1'(cs);
        in_data  = d;
        in_valid = 1'b1;
        check(in_ready == 1'b1, "R7 ready before word", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        mux_cfg  = ~mux_cfg;       // R2: late change must not matter
        if (k == 3) begin
            check(cfg_err == 1'b1, "R6 error pulse", 64'(cfg_err), 64'd1);
            check(out_valid == 1'b0, "R6 no beat", 64'(out_valid), 64'd0);
            @(negedge clk);
            check(cfg_err == 1'b0, "R6 pulse one cycle", 64'(cfg_err), 64'd0);
            check(out_valid == 1'b0 && in_ready == 1'b1, "R6 idle after drop",
                  64'({out_valid, in_ready}), 64'b01);
        end else begin
            nb = (k == 0) ? 2 : 4;
            b = 0;
            toggle = 1'b0;
            while (b < nb) begin
                if (k == 0) begin
                    exp_d = 32'(d >> (32*b));
                    exp_l = 4'b1111;
                end else if (k == 1) begin
                    exp_d = {16'h0, 16'(d >> (16*b))};
                    exp_l = 4'b0011;
                end else begin
                    exp_d = {16'(d >> (16*b)), 16'h0};
                    exp_l = 4'b1100;
                end
                check(out_valid == 1'b1, "R7 beat valid", 64'(out_valid), 64'd1);
                check(in_ready == 1'b0, "R7 input held off", 64'(in_ready), 64'd0);
                check(out_data == exp_d,
                      (k == 0) ? "R3 R2 R8 beat data" : (k == 1) ? "R4 R2 R8 beat data" : "R5 R2 R8 beat data",
                      64'(out_data), 64'(exp_d));
                check(out_lane_en == exp_l,
                      (k == 0) ? "R3 lane enables" : (k == 1) ? "R4 lane enables" : "R5 lane enables",
                      64'(out_lane_en), 64'(exp_l));
                rdy = !(bp && !toggle);
                toggle = ~toggle;
                out_ready = rdy;
                @(negedge clk);
                if (rdy) b++;
            end
            out_ready = 1'b0;
            check(out_valid == 1'b0 && in_ready == 1'b1, "R7 ready after last beat",
                  64'({out_valid, in_ready}), 64'b01);
            check(out_data == '0 && out_lane_en == '0, "R9 idle outputs zero",
                  64'({out_data, out_lane_en}), 64'd0);
        end
    endtask

    initial begin
        logic [63:0] pats [4];
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'hFFFF_0000_A5A5_5A5A;
        pats[2] = 64'h8000_0001_7FFE_C3C3;
        pats[3] = 64'hDEAD_BEEF_F00D_1234;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && cfg_err == 1'b0 && out_lane_en == '0 && in_ready == 1'b1,
              "R1 reset state", 64'({out_valid, cfg_err, out_lane_en, in_ready}), 64'b0000001);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && cfg_err == 1'b0 && out_lane_en == '0 && in_ready == 1'b1,
              "R1 after reset", 64'({out_valid, cfg_err, out_lane_en, in_ready}), 64'b0000001);
        for (int cs = 0; cs < 2; cs++)
            for (int code = 0; code < 8; code++)
                for (int p = 0; p < 4; p++)
                    run_word(cs, code, pats[p] ^ {8{8'(code*17 + cs*5)}}, p[0]);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule